// File: doc/BRIEF.md
# Destination Address Hash Filter

This block sits on the receive side of an Ethernet MAC and decides, for every incoming frame, whether the frame is kept or dropped, using only the frame's 48-bit destination address. The address arrives as six bytes, one per accepted beat, in wire order. While the bytes stream in, the block folds them into a reflected CRC-32. The complemented, bit-reversed result is reduced to an index that picks one bit of a programmable hash table of 64, 128 or 256 bits.

The hash result is combined with an exact compare against the station address, broadcast detection, a multicast test, and a handful of control bits. The outcome is one pass/drop verdict per address. Software loads the hash table as 32-bit words through a simple write port and sets the control bits through the same port. The station address is supplied as a static input.

Top module: `hash_filt_top`

## Requirements
- R1: The hash index is the top log2(TABLE_BITS) bits (6 for the default 64-bit table) of the bit-reversed one's complement of a reflected CRC-32. The CRC uses polynomial 0xEDB88320, starts from all ones, and takes the six address bytes in arrival order, each byte least significant bit first.
- R2: Index bits above the lowest five select a 32-bit table word, and the lowest five bits select the bit within it. Table word k is written at byte offset 0x10 + 4*k. A write to an offset that is misaligned, or that lies past the last table word, changes neither the table nor the control word.
- R3: The control word is written at offset 0x00. Its bits are: bit 0 promiscuous, bit 1 hash for unicast, bit 2 hash for multicast, bit 4 pass every multicast, bit 5 drop broadcast, bit 10 hash-or-exact.
- R4: With promiscuous set, every address passes.
- R5: The all-ones broadcast address passes unless drop-broadcast is set, in which case it is dropped (promiscuous excepted).
- R6: An address whose first byte has bit 0 set is multicast. With pass-every-multicast set, every multicast address passes.
- R7: A unicast address is judged by the hash table only when hash-for-unicast is set, and a multicast address only when hash-for-multicast is set. Otherwise the exact compare with `stationAddr` decides.
- R8: When the hash decides and hash-or-exact is set, the address passes on a hash hit or an exact station match. When hash-or-exact is clear, only a hash hit passes, and an exact match alone is dropped.
- R9: `decisionValid` is high for exactly one cycle: the cycle after the sixth address byte is accepted. Idle cycles between bytes are allowed. `decisionPass` is low whenever `decisionValid` is low.
- R10: A byte accepted with `inFirst` high is taken as byte 0 of a new address, and any partly received address is abandoned without a verdict.
- R11: Reset clears the hash table and all control bits and yields no verdict. After reset, a non-broadcast address passes only if it equals `stationAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inByteValid | input | 1 | An address byte is presented this cycle |
| inFirst | input | 1 | The presented byte is byte 0 of a new address |
| inByte | input | 8 | Address byte |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWrData | input | 32 | Register write data |
| stationAddr | input | 48 | Station address; the first wire byte is in bits 47:40 |
| decisionValid | output | 1 | A verdict is presented this cycle |
| decisionPass | output | 1 | Verdict: 1 keep, 0 drop |

## Verification
The assertions take for granted that each address reaches the block as six accepted bytes. That means two verdicts can never fall in adjacent cycles, and every verdict is preceded by an accepted byte. They also assume that the promiscuous bit is changed only through writes to offset 0x00. The stimulus always sends complete six-byte addresses, with at most one deliberately abandoned partial address that is restarted with `inFirst`. It changes control bits only between addresses, so every verdict is judged against one settled configuration.

// File: rtl/hash_filt_pkg.sv
package hash_filt_pkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  // control word bit positions (software-visible)
  localparam int CTL_PROMISC   = 0;
  localparam int CTL_HASH_UC   = 1;
  localparam int CTL_HASH_MC   = 2;
  localparam int CTL_ALL_MC    = 4;
  localparam int CTL_DROP_BC   = 5;
  localparam int CTL_HASH_OR_X = 10;

  typedef struct packed {
    logic promisc;
    logic hashUc;
    logic hashMc;
    logic allMc;
    logic dropBc;
    logic hashOrExact;
  } filtCtl_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       byteTake;
    logic       byteRestart;
    logic       ctrlWr;
    logic       tblWr;
    logic [7:0] tblSel;
  } hfStrobes_t;

  function automatic logic [31:0] crcByte(input logic [31:0] crcIn, input logic [7:0] data);
    logic [31:0] c;
    logic fb;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ data[i];
      c = {1'b0, c[31:1]} ^ (fb ? CRC_POLY : 32'h0);
    end
    return c;
  endfunction

endpackage

// File: rtl/hash_filt_ctrl.sv
module hash_filt_ctrl
  import hash_filt_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int TABLE_WORDS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inByteValid,
  input  logic              inFirst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output hfStrobes_t        stb,
  output logic              doneValid
);

  localparam int CTRL_OFF = 'h00;
  localparam int TBL_OFF  = 'h10;
  localparam int TBL_END  = TBL_OFF + 4 * TABLE_WORDS;
  localparam int LAST_POS = 5;

  logic [2:0] cntQ;
  logic [2:0] pos;
  logic       lastByte;
  logic       doneQ;
  int         addrInt;
  int         tblOffset;

  assign pos      = inFirst ? 3'd0 : cntQ;
  assign lastByte = inByteValid && (pos == 3'(LAST_POS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= 3'd0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= lastByte;
      if (inByteValid) begin
        cntQ <= (pos == 3'(LAST_POS)) ? 3'd0 : pos + 3'd1;
      end
    end
  end

  assign doneValid = doneQ;

  always_comb begin
    addrInt   = int'(regAddr);
    tblOffset = addrInt - TBL_OFF;
    stb.byteTake    = inByteValid;
    stb.byteRestart = inByteValid && (pos == 3'd0);
    stb.ctrlWr      = regWrEn && (addrInt == CTRL_OFF);
    stb.tblWr       = regWrEn && (addrInt >= TBL_OFF) && (addrInt < TBL_END)
                      && (regAddr[1:0] == 2'b00);
    stb.tblSel      = 8'(tblOffset >> 2);
  end

endmodule

// File: rtl/hash_filt_dp.sv
module hash_filt_dp
  import hash_filt_pkg::*;
#(
  parameter int TABLE_BITS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  hfStrobes_t  stb,
  input  logic        doneValid,
  input  logic [7:0]  inByte,
  input  logic [31:0] regWrData,
  input  logic [47:0] stationAddr,
  output logic        decisionPass
);

  localparam int TABLE_WORDS = TABLE_BITS / 32;
  localparam int IDX_W       = $clog2(TABLE_BITS);
  localparam int SEL_W       = IDX_W - 5;

  logic [31:0] crcQ;
  logic [47:0] addrQ;
  filtCtl_t    ctlQ;
  logic [31:0] tblWordQ [TABLE_WORDS];

  logic [IDX_W-1:0] hashIdx;
  logic [SEL_W-1:0] wordSel;
  logic [4:0]       bitSel;
  logic             hashHit;
  logic             isBcast;
  logic             isMcast;
  logic             exactHit;
  logic             useHash;
  logic             passRaw;

  // top IDX_W bits of bitrev(~crc): bit j of the index is ~crc[IDX_W-1-j]
  function automatic logic [IDX_W-1:0] hashIndex(input logic [31:0] crc);
    logic [31:0] folded;
    logic [31:0] rev;
    folded = ~crc;
    for (int k = 0; k < 32; k++) rev[k] = folded[31-k];
    return rev[31 -: IDX_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ  <= '1;
      addrQ <= '0;
    end else if (stb.byteTake) begin
      crcQ  <= crcByte(stb.byteRestart ? 32'hFFFF_FFFF : crcQ, inByte);
      addrQ <= stb.byteRestart ? {40'h0, inByte} : {addrQ[39:0], inByte};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ <= '0;
    end else if (stb.ctrlWr) begin
      ctlQ.promisc     <= regWrData[CTL_PROMISC];
      ctlQ.hashUc      <= regWrData[CTL_HASH_UC];
      ctlQ.hashMc      <= regWrData[CTL_HASH_MC];
      ctlQ.allMc       <= regWrData[CTL_ALL_MC];
      ctlQ.dropBc      <= regWrData[CTL_DROP_BC];
      ctlQ.hashOrExact <= regWrData[CTL_HASH_OR_X];
    end
  end

  for (genvar w = 0; w < TABLE_WORDS; w++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tblWordQ[w] <= '0;
      end else if (stb.tblWr && (stb.tblSel == 8'(w))) begin
        tblWordQ[w] <= regWrData;
      end
    end
  end

  assign hashIdx  = hashIndex(crcQ);
  assign wordSel  = hashIdx[IDX_W-1:5];
  assign bitSel   = hashIdx[4:0];
  assign hashHit  = tblWordQ[wordSel][bitSel];
  assign isBcast  = &addrQ;
  assign isMcast  = addrQ[40];
  assign exactHit = (addrQ == stationAddr);
  assign useHash  = isMcast ? ctlQ.hashMc : ctlQ.hashUc;

  always_comb begin
    if (ctlQ.promisc) begin
      passRaw = 1'b1;
    end else if (isBcast) begin
      passRaw = !ctlQ.dropBc;
    end else if (isMcast && ctlQ.allMc) begin
      passRaw = 1'b1;
    end else if (useHash) begin
      passRaw = ctlQ.hashOrExact ? (hashHit || exactHit) : hashHit;
    end else begin
      passRaw = exactHit;
    end
  end

  assign decisionPass = doneValid && passRaw;

endmodule

// File: rtl/hash_filt_top.sv
module hash_filt_top
  import hash_filt_pkg::*;
#(
  parameter int TABLE_BITS = 64,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inByteValid,
  input  logic              inFirst,
  input  logic [7:0]        inByte,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic [47:0]       stationAddr,
  output logic              decisionValid,
  output logic              decisionPass
);

  localparam int TABLE_WORDS = TABLE_BITS / 32;

  hfStrobes_t stb;
  logic       doneValid;

  hash_filt_ctrl #(
    .ADDR_W     (ADDR_W),
    .TABLE_WORDS(TABLE_WORDS)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inByteValid(inByteValid),
    .inFirst    (inFirst),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .stb        (stb),
    .doneValid  (doneValid)
  );

  hash_filt_dp #(
    .TABLE_BITS(TABLE_BITS)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .doneValid   (doneValid),
    .inByte      (inByte),
    .regWrData   (regWrData),
    .stationAddr (stationAddr),
    .decisionPass(decisionPass)
  );

  assign decisionValid = doneValid;

endmodule

// File: rtl/hash_filt_chk.sv
module hash_filt_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inByteValid,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrBit0,
  input logic              decisionValid,
  input logic              decisionPass
);

  logic promiscSeen;

  always_ff @(posedge clk) begin
    if (!rstN) promiscSeen <= 1'b0;
    else if (regWrEn && (regAddr == '0)) promiscSeen <= wrBit0;
  end

  assert_pass_needs_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    decisionPass |-> decisionValid);

  assert_single_cycle_verdict_R9: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |=> !decisionValid);

  assert_verdict_after_byte_R9: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |-> $past(inByteValid));

  assert_promisc_passes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && promiscSeen) |-> decisionPass);

endmodule

bind hash_filt_top hash_filt_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .inByteValid  (inByteValid),
  .regWrEn      (regWrEn),
  .regAddr      (regAddr),
  .wrBit0       (regWrData[0]),
  .decisionValid(decisionValid),
  .decisionPass (decisionPass)
);

// File: tb/hash_filt_top_tb_top.sv
module hash_filt_top_tb_top;

  localparam int TABLE_BITS  = 64;
  localparam int ADDR_W      = 8;
  localparam int TABLE_WORDS = TABLE_BITS / 32;
  localparam int IDX_W       = $clog2(TABLE_BITS);
  localparam int WATCHDOG    = 100000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inByteValid = 1'b0;
  logic              inFirst = 1'b0;
  logic [7:0]        inByte = 8'h00;
  logic              regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0]       regWrData = '0;
  logic [47:0]       stationAddr = 48'h02AA_BBCC_DDEE;
  logic              decisionValid;
  logic              decisionPass;

  int checks = 0;
  int fails  = 0;

  bit    expQ[$];
  string tagQ[$];

  // shadow configuration, maintained from the requirements
  logic [TABLE_BITS-1:0] tblShadow = '0;
  logic [31:0]           ctlShadow = '0;

  always #10 clk = ~clk;  // 50 MHz

  hash_filt_top #(.TABLE_BITS(TABLE_BITS), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .inByteValid(inByteValid), .inFirst(inFirst),
    .inByte(inByte), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .stationAddr(stationAddr), .decisionValid(decisionValid), .decisionPass(decisionPass)
  );

  function automatic int benchIdx(input logic [47:0] a);
    logic [31:0] c;
    logic [31:0] r;
    logic [31:0] rev;
    logic [7:0]  b;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      b = a[47 - 8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        if (c[0] ^ b[j]) c = (c >> 1) ^ 32'hEDB88320;
        else             c = c >> 1;
      end
    end
    r = ~c;
    for (int k = 0; k < 32; k++) rev[k] = r[31-k];
    return int'(rev >> (32 - IDX_W));
  endfunction

  function automatic bit model(input logic [47:0] a);
    bit mc, useH, hit, ex;
    mc   = a[40];
    ex   = (a == stationAddr);
    hit  = tblShadow[benchIdx(a)];
    useH = mc ? ctlShadow[2] : ctlShadow[1];
    if (ctlShadow[0]) return 1'b1;
    if (&a) return !ctlShadow[5];
    if (mc && ctlShadow[4]) return 1'b1;
    if (useH) return ctlShadow[10] ? (hit | ex) : hit;
    return ex;
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input int off, input logic [31:0] data, input bit legal);
    regWrEn   = 1'b1;
    regAddr   = ADDR_W'(off);
    regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    if (legal) begin
      if (off == 0) ctlShadow = data;
      else tblShadow[(off - 'h10) / 4 * 32 +: 32] = data;
    end
  endtask

  task automatic setHashBit(input int idx);
    logic [TABLE_BITS-1:0] t;
    t = tblShadow;
    t[idx] = 1'b1;
    writeReg('h10 + 4 * (idx / 32), t[(idx / 32) * 32 +: 32], 1'b1);
  endtask

  task automatic sendAddr(input logic [47:0] a, input int gap, input string req);
    expQ.push_back(model(a));
    tagQ.push_back(req);
    for (int i = 0; i < 6; i++) begin
      inByteValid = 1'b1;
      inFirst     = (i == 0);
      inByte      = a[47 - 8*i -: 8];
      @(negedge clk);
      inByteValid = 1'b0;
      inFirst     = 1'b0;
      if (i < 5) repeat (gap) @(negedge clk);
    end
  endtask

  // monitor: compares verdicts against the scoreboard queue
  always @(negedge clk) begin
    if (rstN) begin
      if (decisionValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R10", "unexpected verdict", 1, 0);
        end else begin
          bit e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(decisionPass == e, t, "verdict", int'(decisionPass), int'(e));
        end
      end else if (decisionPass) begin
        check(1'b0, "R9", "pass without valid", 1, 0);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual %0d expected %0d", WATCHDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [47:0] addrA, addrB, addrM, junk;
    int idxS, idxA;
    repeat (3) @(negedge clk);
    check(decisionValid == 1'b0, "R11", "valid during reset", int'(decisionValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(decisionValid == 1'b0, "R11", "valid after reset", int'(decisionValid), 0);

    idxS  = benchIdx(stationAddr);
    addrA = 48'h0211_2233_4455;
    while (benchIdx(addrA) == idxS) addrA = addrA + 48'h1;
    idxA  = benchIdx(addrA);
    addrB = addrA + 48'h1;
    while (benchIdx(addrB) == idxA || benchIdx(addrB) == idxS) addrB = addrB + 48'h1;
    addrM = 48'h0100_5E00_0001;
    while (benchIdx(addrM) == idxA || benchIdx(addrM) == idxS) addrM = addrM + 48'h1;

    // R11: after reset only exact station match (and broadcast) passes
    sendAddr(stationAddr, 0, "R11");
    sendAddr(addrA, 0, "R11");
    sendAddr(addrM, 0, "R11");
    sendAddr(48'hFFFF_FFFF_FFFF, 0, "R5");

    // R1/R2/R7: hash lookup for unicast
    setHashBit(idxA);
    sendAddr(addrA, 0, "R7");            // hashing off: drop
    writeReg('h0, 32'h0000_0002, 1'b1);  // hash for unicast
    sendAddr(addrA, 0, "R1");            // hit
    sendAddr(addrB, 0, "R2");            // miss
    sendAddr(stationAddr, 0, "R8");      // exact only, hash-or-exact clear: drop
    writeReg('h0, 32'h0000_0402, 1'b1);  // + hash-or-exact
    sendAddr(stationAddr, 0, "R8");
    sendAddr(addrB, 0, "R8");

    // R7: multicast uses hash only with hash-for-multicast
    sendAddr(addrM, 0, "R7");
    setHashBit(benchIdx(addrM));
    sendAddr(addrM, 0, "R7");
    writeReg('h0, 32'h0000_0406, 1'b1);
    sendAddr(addrM, 0, "R7");
    sendAddr(addrM ^ 48'h0000_0000_0F00, 0, "R7");

    // R6: pass every multicast
    writeReg('h0, 32'h0000_0010, 1'b1);
    sendAddr(48'h0300_0000_1234, 0, "R6");
    sendAddr(addrB, 0, "R6");

    // R5: drop broadcast
    writeReg('h0, 32'h0000_0020, 1'b1);
    sendAddr(48'hFFFF_FFFF_FFFF, 0, "R5");
    sendAddr(stationAddr, 0, "R5");

    // R2/R3: ignored writes
    writeReg('h0, 32'h0000_0002, 1'b1);
    writeReg('h10 + 4 * TABLE_WORDS, 32'hFFFF_FFFF, 1'b0);
    writeReg('h11, 32'hFFFF_FFFF, 1'b0);
    writeReg('h04, 32'hFFFF_FFFF, 1'b0);
    sendAddr(addrB, 0, "R2");
    sendAddr(addrA, 0, "R3");

    // R9: idle cycles between bytes
    sendAddr(addrA, 2, "R9");
    sendAddr(addrB, 1, "R9");

    // R10: abandoned partial address, then a restart
    junk = 48'h0123_4567_89AB;
    for (int i = 0; i < 3; i++) begin
      inByteValid = 1'b1;
      inFirst     = (i == 0);
      inByte      = junk[47 - 8*i -: 8];
      @(negedge clk);
    end
    inByteValid = 1'b0;
    inFirst     = 1'b0;
    sendAddr(addrA, 0, "R10");

    // R4: promiscuous
    writeReg('h0, 32'h0000_0021, 1'b1);
    sendAddr(addrB, 0, "R4");
    sendAddr(48'hFFFF_FFFF_FFFF, 0, "R4");
    sendAddr(addrM, 0, "R4");

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R9", "verdicts outstanding", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule